// File: doc/BRIEF.md
# Time-of-Day Clock Core

This block is a bus-attached real-time clock. It keeps a packed day, hour, minute and second count, which a divider clocked by a 32768 Hz enable strobe advances. The count is compared against a time-of-day alarm. The block also raises periodic events at half-second, second, minute, hour and day boundaries. Each event has its own sticky status flag, which software clears by writing a 1 to it. A single interrupt output collects the flags whose enable bits are set. A wakeup output follows the alarm flag.

Writes to the counter, alarm and control words do not take effect at once. They are held in one pending slot per register and applied on the next slow tick, which stands for the crossing into the slow clock domain. A write-done status bit is low while any of these updates is still pending. Software may keep writing while write-done is low. Nothing is lost: every pending slot is applied at that tick, and the newest value written to each register is the one that takes effect.

Top module: `tod_clock_core`

## Requirements
- R1: Byte offset 0x00 reads the identity code 0x030110 in bits [31:8] and the revision parameter in bits [7:0]. Offset 0x04 and any unmapped offset read 0. Offset 0x20 is a plain 32-bit scratch register that is written at once and does not affect write-done.
- R2: The counter word at 0x10 and the alarm word at 0x14 hold seconds in [5:0], minutes in [11:6], hours in [16:12] and the day number in [31:17].
- R3: While counting is enabled, the divider advances once per slow tick. The half-second flag is set at ticks SUB_DIV/2 and SUB_DIV of each period. The seconds value advances only on tick SUB_DIV. Loading the counter restarts the divider. Between ticks the counter never changes.
- R4: Seconds roll from 59 to 0 into minutes, minutes roll from 59 to 0 into hours, and hours roll from 23 to 0 into the day. The 15-bit day field wraps from 0x7FFF to 0.
- R5: Control bit 0 enables counting. While it is 0, ticks leave the counter unchanged and set no periodic flag.
- R6: Status bit 2 (alarm) is set when the count advances to a time whose hour, minute and second equal those of the alarm word. The day field of the alarm is ignored.
- R7: Status bits 3, 4, 5, 6 and 7 are set at day, hour, minute, second and half-second boundaries respectively.
- R8: Status flags are sticky until a write to 0x1C with a 1 in their bit position. A status write leaves write-done unchanged.
- R9: The interrupt output is high when any status bit in [7:2] is set together with the control bit at the same position. The wakeup output is high when status bit 2 and control bit 1 are both set.
- R10: Status bit 16 (write-done) goes low on the cycle after a write to 0x10, 0x14 or 0x18. It returns high on the cycle after the next slow tick. Until then, reads of that register return the value it held before the write.
- R11: Writes accepted while write-done is low are queued, not dropped. All pending registers are applied on the same tick, and the last value written to each register wins.
- R12: After reset the counter, alarm, control and status flags are 0 and write-done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtcTick | input | 1 | One-cycle strobe at the 32768 Hz slow-clock rate |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register, combinational |
| irqOut | output | 1 | Masked OR of the status flags |
| wakeOut | output | 1 | Alarm wakeup request |

## Verification
The embedded assertions check, on every cycle, that write-done drops after every synchronised write and rises only after a slow tick. They also check that pending updates are held until a tick, that the count is frozen between ticks and while counting is disabled, that the alarm flag stays sticky until cleared, and that seconds wrap at 59. Only the bench scenarios can show the values themselves: the full carry chain from seconds into the day, the day wrap, an alarm match against a garbage day field, interrupt masking with mixed enables, and several queued writes being applied together with the last value winning.

// File: rtl/tod_clock_pkg.sv
package tod_clock_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_ID   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RSV  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ALM  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_STS  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_TRIM = 8'h20;

  localparam logic [23:0] ID_CODE = 24'h030110;

  // control bit positions; periodic/alarm enables share positions with status flags
  localparam int unsigned CT_RUN  = 0;
  localparam int unsigned CT_WAKE = 1;
  localparam int unsigned FL_LO   = 2;
  localparam int unsigned FL_HI   = 7;
  localparam int unsigned FL_W    = FL_HI - FL_LO + 1;
  localparam int unsigned ST_DONE = 16;

  typedef struct packed {
    logic [14:0] day;
    logic [4:0]  hour;
    logic [5:0]  min;
    logic [5:0]  sec;
  } tod_t;

  typedef struct packed {
    logic tick;
    logic ldCnt;
    logic ldAlm;
    logic ldCtl;
    logic clrSts;
  } strobe_t;
endpackage

// File: rtl/tod_clock_ctrl.sv
module tod_clock_ctrl
  import tod_clock_pkg::*;
#(
  parameter logic [7:0] REV = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcTick,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  tod_t              cntVal,
  input  logic [DATA_W-1:0] almVal,
  input  logic [7:0]        ctlVal,
  input  logic [FL_W-1:0]   flagVal,
  output strobe_t           stb,
  output logic [DATA_W-1:0] cntData,
  output logic [DATA_W-1:0] almData,
  output logic [7:0]        ctlData,
  output logic [DATA_W-1:0] busRdata
);
  logic wrEn, selCnt, selAlm, selCtl, selSts, selTrim;
  logic pendCnt, pendAlm, pendCtl, writeDone;
  logic [DATA_W-1:0] trimReg;

  assign wrEn    = busValid & busWrite;
  assign selCnt  = (busAddr == OFS_CNT);
  assign selAlm  = (busAddr == OFS_ALM);
  assign selCtl  = (busAddr == OFS_CTL);
  assign selSts  = (busAddr == OFS_STS);
  assign selTrim = (busAddr == OFS_TRIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= 1'b0;
      pendAlm <= 1'b0;
      pendCtl <= 1'b0;
      cntData <= '0;
      almData <= '0;
      ctlData <= '0;
      trimReg <= '0;
    end else begin
      if (rtcTick) begin
        pendCnt <= 1'b0;
        pendAlm <= 1'b0;
        pendCtl <= 1'b0;
      end
      if (wrEn && selCnt) begin
        pendCnt <= 1'b1;
        cntData <= busWdata;
      end
      if (wrEn && selAlm) begin
        pendAlm <= 1'b1;
        almData <= busWdata;
      end
      if (wrEn && selCtl) begin
        pendCtl <= 1'b1;
        ctlData <= busWdata[7:0];
      end
      if (wrEn && selTrim) trimReg <= busWdata;
    end
  end

  assign writeDone  = ~(pendCnt | pendAlm | pendCtl);
  assign stb.tick   = rtcTick;
  assign stb.ldCnt  = rtcTick & pendCnt;
  assign stb.ldAlm  = rtcTick & pendAlm;
  assign stb.ldCtl  = rtcTick & pendCtl;
  assign stb.clrSts = wrEn & selSts;

  always_comb begin
    unique case (busAddr)
      OFS_ID:   busRdata = {ID_CODE, REV};
      OFS_CNT:  busRdata = cntVal;
      OFS_ALM:  busRdata = almVal;
      OFS_CTL:  busRdata = {24'd0, ctlVal};
      OFS_STS:  busRdata = {15'd0, writeDone, 8'd0, flagVal, 2'b00};
      OFS_TRIM: busRdata = trimReg;
      default:  busRdata = '0;
    endcase
  end

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (selCnt || selAlm || selCtl) |=> !writeDone); // R10
  AST_DONE_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeDone) |-> $past(rtcTick)); // R10
  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt && !rtcTick |=> pendCnt); // R11
endmodule

// File: rtl/tod_clock_dp.sv
module tod_clock_dp
  import tod_clock_pkg::*;
#(
  parameter int unsigned SUB_DIV = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] cntData,
  input  logic [DATA_W-1:0] almData,
  input  logic [7:0]        ctlData,
  input  logic [FL_W-1:0]   clrMask,
  output tod_t              cntVal,
  output logic [DATA_W-1:0] almVal,
  output logic [7:0]        ctlVal,
  output logic [FL_W-1:0]   flagVal,
  output logic              irqOut,
  output logic              wakeOut
);
  localparam int unsigned DIV_W = $clog2(SUB_DIV);
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(SUB_DIV / 2 - 1);
  localparam logic [DIV_W-1:0] FULL_LAST = DIV_W'(SUB_DIV - 1);

  tod_t todNow, todNxt, almTod;
  logic [DIV_W-1:0] divCnt;
  logic [7:0] ctlReg;
  logic [FL_W-1:0] flags, setVec, clrVec;
  logic run, halfP, secP, minP, hourP, dayP, almHit;

  assign almTod = tod_t'(almVal);

  always_comb begin
    run    = stb.tick & ctlReg[CT_RUN] & ~stb.ldCnt;
    secP   = run & (divCnt == FULL_LAST);
    halfP  = run & ((divCnt == HALF_LAST) | (divCnt == FULL_LAST));
    minP   = secP & (todNow.sec == 6'd59);
    hourP  = minP & (todNow.min == 6'd59);
    dayP   = hourP & (todNow.hour == 5'd23);
    todNxt = todNow;
    if (secP) begin
      if (todNow.sec != 6'd59) todNxt.sec = todNow.sec + 6'd1;
      else begin
        todNxt.sec = '0;
        if (todNow.min != 6'd59) todNxt.min = todNow.min + 6'd1;
        else begin
          todNxt.min = '0;
          if (todNow.hour != 5'd23) todNxt.hour = todNow.hour + 5'd1;
          else begin
            todNxt.hour = '0;
            todNxt.day  = todNow.day + 15'd1;
          end
        end
      end
    end
    almHit = secP & (todNxt.hour == almTod.hour) & (todNxt.min == almTod.min)
                  & (todNxt.sec == almTod.sec);
    setVec = {halfP, secP, minP, hourP, dayP, almHit};
    clrVec = stb.clrSts ? clrMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      todNow <= '0;
      divCnt <= '0;
      almVal <= '0;
      ctlReg <= '0;
      flags  <= '0;
    end else begin
      if (stb.ldCnt) begin
        todNow <= tod_t'(cntData);
        divCnt <= '0;
      end else if (run) begin
        todNow <= todNxt;
        divCnt <= (divCnt == FULL_LAST) ? '0 : divCnt + 1'b1;
      end
      if (stb.ldAlm) almVal <= almData;
      if (stb.ldCtl) ctlReg <= ctlData;
      flags <= (flags & ~clrVec) | setVec;
    end
  end

  assign cntVal  = todNow;
  assign ctlVal  = ctlReg;
  assign flagVal = flags;
  assign irqOut  = |(flags & ctlReg[FL_HI:FL_LO]);
  assign wakeOut = flags[0] & ctlReg[CT_WAKE];

  AST_FROZEN_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick |=> $stable(todNow)); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick && !ctlReg[CT_RUN] && !stb.ldCnt |=> $stable(todNow)); // R5
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flags[0] && !(stb.clrSts && clrMask[0]) |=> flags[0]); // R8
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    secP && todNow.sec == 6'd59 |=> todNow.sec == 6'd0); // R4
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
  import tod_clock_pkg::*;
#(
  parameter int unsigned SUB_DIV = 32768,
  parameter logic [7:0]  REV     = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcTick,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              wakeOut
);
  strobe_t stb;
  tod_t cntVal;
  logic [DATA_W-1:0] cntData, almData, almVal;
  logic [7:0] ctlData, ctlVal;
  logic [FL_W-1:0] flagVal;

  tod_clock_ctrl #(.REV(REV)) uCtrl (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .cntVal(cntVal), .almVal(almVal), .ctlVal(ctlVal), .flagVal(flagVal),
    .stb(stb), .cntData(cntData), .almData(almData), .ctlData(ctlData),
    .busRdata(busRdata)
  );

  tod_clock_dp #(.SUB_DIV(SUB_DIV)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntData(cntData), .almData(almData),
    .ctlData(ctlData), .clrMask(busWdata[FL_HI:FL_LO]), .cntVal(cntVal),
    .almVal(almVal), .ctlVal(ctlVal), .flagVal(flagVal), .irqOut(irqOut),
    .wakeOut(wakeOut)
  );
endmodule

// File: tb/tod_clock_core_test.sv
module tod_clock_core_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rtcTick = 1'b0;
  logic busValid = 1'b0;
  logic busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut, wakeOut;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  tod_clock_core #(.SUB_DIV(4), .REV(8'h01)) uut (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  function automatic logic [31:0] tod(int d, int h, int m, int s);
    return {15'(d), 5'(h), 6'(m), 6'(s)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each read as the design returns it
  always @(negedge clk) begin
    if (busValid && !busWrite) begin
      if (expQ.size() == 0) chk("unexpected read", busRdata, 32'hx);
      else chk(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #2;
    expQ.push_back(exp); tagQ.push_back(tag);
    busValid = 1; busWrite = 0; busAddr = a;
    @(posedge clk); #2;
    busValid = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; rtcTick = 1;
      @(posedge clk); #2; rtcTick = 0;
    end
  endtask

  task automatic pins(logic irqE, logic wakeE, string tag);
    @(negedge clk);
    chk({tag, " irq"}, {31'd0, irqOut}, {31'd0, irqE});
    chk({tag, " wake"}, {31'd0, wakeOut}, {31'd0, wakeE});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #2; rstN = 1;
    rd(8'h00, 32'h03011001, "R1 identity");
    rd(8'h1C, 32'h00010000, "R12 reset status");
    rd(8'h10, 32'h0, "R12 reset counter");
    rd(8'h18, 32'h0, "R12 reset control");
    pins(0, 0, "R12 reset");

    wr(8'h10, tod(0, 23, 59, 58));
    rd(8'h1C, 32'h0, "R10 done low after counter write");
    rd(8'h10, 32'h0, "R10 counter not yet applied");
    ticks(1);
    rd(8'h10, tod(0, 23, 59, 58), "R2 counter applied");
    rd(8'h1C, 32'h00010000, "R10 done back high");

    wr(8'h18, 32'h00);
    wr(8'h18, 32'hFF);
    wr(8'h14, tod(32'h7FFF, 23, 59, 59));
    rd(8'h18, 32'h0, "R10 control not yet applied");
    ticks(1);
    rd(8'h18, 32'hFF, "R11 last control write wins");
    rd(8'h14, tod(32'h7FFF, 23, 59, 59), "R11 alarm applied same tick");
    rd(8'h1C, 32'h00010000, "R11 all pending cleared");

    ticks(2);
    rd(8'h1C, 32'h00010080, "R3 half-second flag");
    rd(8'h10, tod(0, 23, 59, 58), "R3 no second yet");
    ticks(2);
    rd(8'h10, tod(0, 23, 59, 59), "R3 second advance");
    rd(8'h1C, 32'h000100C4, "R6 alarm hit ignoring day");
    pins(1, 1, "R9 alarm outputs");

    wr(8'h1C, 32'hFC);
    rd(8'h1C, 32'h00010000, "R8 clear keeps done");
    pins(0, 0, "R8 cleared outputs");

    ticks(4);
    rd(8'h10, tod(1, 0, 0, 0), "R4 carry into day");
    rd(8'h1C, 32'h000100F8, "R7 all boundary flags");

    wr(8'h1C, 32'hFF);
    wr(8'h18, 32'hFE);
    ticks(1);
    rd(8'h18, 32'hFE, "R5 control off");
    ticks(4);
    rd(8'h10, tod(1, 0, 0, 0), "R5 counter held");
    rd(8'h1C, 32'h00010000, "R5 no flags while off");

    wr(8'h18, 32'h41);
    ticks(5);
    rd(8'h10, tod(1, 0, 0, 1), "R3 resumes");
    rd(8'h1C, 32'h000100C0, "R7 second and half flags");
    pins(1, 0, "R9 second enabled");
    wr(8'h1C, 32'h40);
    rd(8'h1C, 32'h00010080, "R8 clear one bit");
    pins(0, 0, "R9 half masked");

    wr(8'h1C, 32'hFF);
    wr(8'h10, tod(32'h7FFF, 23, 59, 59));
    ticks(5);
    rd(8'h10, 32'h0, "R4 day wrap");
    rd(8'h1C, 32'h000100F8, "R4 wrap flags");

    wr(8'h20, 32'hA5A51234);
    rd(8'h1C, 32'h000100F8, "R1 trim leaves done");
    rd(8'h20, 32'hA5A51234, "R1 trim readback");
    rd(8'h04, 32'h0, "R1 reserved");
    rd(8'h3C, 32'h0, "R1 unmapped");

    repeat (3) @(negedge clk);
    chk("queue drained", 32'(expQ.size()), 32'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule